// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This unit generates the hold and flush controls for the fetch, decode and execute pipeline registers of a five-stage in-order processor. The five stages are fetch, decode, execute, memory and writeback. It looks at four things: the opcodes in the decode, execute and memory registers, the memory destination register of the execute stage, the two source registers read in decode, and the branch-condition result computed in execute.

A hold keeps a register's contents for one more cycle. A flush replaces its contents with a no-op. The pipeline registers act on these controls at the next clock edge. The unit holds no state, so every output follows its inputs within the same cycle.

Three hazards are handled:
- A load-to-use dependence costs one cycle.
- A mispredicted not-taken conditional jump costs two cycles. The predictor guesses taken.
- A return costs three cycles while it passes through the pipeline.

When hazards coincide, fixed priorities apply. A load-to-use dependence beats the return flush, so decode is held and never held and flushed at once. A mispredict that coincides with a return is treated as a mispredict.

Top module: `hazard_ctl`

## Requirements
- R1: When exe_op is the load opcode (5) or the pop opcode (11), and exe_dst_mem equals dec_src_a or dec_src_b, then fetch_stall, dec_stall and exe_bubble are all 1.
- R2: A exe_dst_mem of 15 (the "no register" code) never forms a load-to-use match, even if a source also reads 15.
- R3: dec_stall is 1 exactly when the load-to-use condition of R1 holds.
- R4: fetch_stall is 1 when the return opcode (9) is in any of dec_op, exe_op or mem_op.
- R5: With a return in any of those stages and no load-to-use hazard, dec_bubble is 1.
- R6: With exe_op equal to the conditional-jump opcode (7) and exe_cond_true 0, dec_bubble and exe_bubble are both 1. With exe_cond_true 1, the jump causes no flush.
- R7: When a load-to-use hazard and a return coincide, dec_stall is 1 and dec_bubble is 0, so the return stays in decode for another cycle.
- R8: When a mispredicted jump in execute coincides with a return in decode, dec_bubble, exe_bubble and fetch_stall are all 1.
- R9: dec_stall and dec_bubble are never 1 together.
- R10: With no hazard present, all four outputs are 0. All outputs are combinational in the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Opcode in the decode register |
| exe_op | input | 4 | Opcode in the execute register |
| mem_op | input | 4 | Opcode in the memory register |
| exe_dst_mem | input | 4 | Register the execute-stage instruction will load from memory |
| dec_src_a | input | 4 | First source register read in decode |
| dec_src_b | input | 4 | Second source register read in decode |
| exe_cond_true | input | 1 | Branch condition evaluated in execute |
| fetch_stall | output | 1 | Hold the fetch register |
| dec_stall | output | 1 | Hold the decode register |
| dec_bubble | output | 1 | Flush the decode register |
| exe_bubble | output | 1 | Flush the execute register |

## Verification
The bench builds the unit with the default widths and opcode values: 4-bit opcodes and register codes, with 15 as the "no register" code. At these widths every opcode triple in the three stages can be swept against both branch outcomes and several register patterns. That sweep reaches every pairing and every triple of hazards.

A second sweep covers every destination and source combination with a load in execute and a return in decode. This reaches the priority case and the reserved-code exclusion exhaustively.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
    typedef struct packed {
        logic fetch_hold;
        logic dec_hold;
        logic dec_flush;
        logic exe_flush;
    } hzc_ctrl_t;
endpackage

// File: rtl/hzc_load_use.sv
module hzc_load_use #(
    parameter int OP_W  = 4,
    parameter int REG_W = 4,
    parameter int NSRC  = 2,
    parameter logic [OP_W-1:0]  OP_LOAD = 4'h5,
    parameter logic [OP_W-1:0]  OP_POP  = 4'hB,
    parameter logic [REG_W-1:0] NO_REG  = 4'hF
) (
    input  logic [OP_W-1:0]             exe_op,
    input  logic [REG_W-1:0]            exe_dst,
    input  logic [NSRC-1:0][REG_W-1:0]  srcs,
    output logic                        hit
);
    logic [NSRC-1:0] src_match;
    logic            reads_mem;
    logic            dst_real;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign src_match[i] = (srcs[i] == exe_dst);
    end

    assign reads_mem = (exe_op == OP_LOAD) || (exe_op == OP_POP);
    assign dst_real  = (exe_dst != NO_REG);
    assign hit       = reads_mem && dst_real && (|src_match);
endmodule

// File: rtl/hzc_ret_track.sv
module hzc_ret_track #(
    parameter int OP_W   = 4,
    parameter int NSTAGE = 3,
    parameter logic [OP_W-1:0] OP_RET = 4'h9
) (
    input  logic [NSTAGE-1:0][OP_W-1:0] stage_ops,
    output logic                        ret_busy
);
    logic [NSTAGE-1:0] is_ret;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        assign is_ret[s] = (stage_ops[s] == OP_RET);
    end

    assign ret_busy = |is_ret;
endmodule

// File: rtl/hzc_mispredict.sv
module hzc_mispredict #(
    parameter int OP_W = 4,
    parameter logic [OP_W-1:0] OP_JXX = 4'h7
) (
    input  logic [OP_W-1:0] exe_op,
    input  logic            cond_true,
    output logic            wrong_path
);
    assign wrong_path = (exe_op == OP_JXX) && !cond_true;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl #(
    parameter int OP_W  = 4,
    parameter int REG_W = 4,
    parameter logic [OP_W-1:0]  OP_LOAD = 4'h5,
    parameter logic [OP_W-1:0]  OP_POP  = 4'hB,
    parameter logic [OP_W-1:0]  OP_JXX  = 4'h7,
    parameter logic [OP_W-1:0]  OP_RET  = 4'h9,
    parameter logic [REG_W-1:0] NO_REG  = 4'hF
) (
    input  logic [OP_W-1:0]  dec_op,
    input  logic [OP_W-1:0]  exe_op,
    input  logic [OP_W-1:0]  mem_op,
    input  logic [REG_W-1:0] exe_dst_mem,
    input  logic [REG_W-1:0] dec_src_a,
    input  logic [REG_W-1:0] dec_src_b,
    input  logic             exe_cond_true,
    output logic             fetch_stall,
    output logic             dec_stall,
    output logic             dec_bubble,
    output logic             exe_bubble
);
    import hzc_pkg::*;

    localparam int NSRC   = 2;
    localparam int NSTAGE = 3;

    logic [NSRC-1:0][REG_W-1:0]  srcs;
    logic [NSTAGE-1:0][OP_W-1:0] stage_ops;
    logic       lu_hit;
    logic       ret_busy;
    logic       wrong_path;
    hzc_ctrl_t  ctrl_d;

    assign srcs      = {dec_src_b, dec_src_a};
    assign stage_ops = {mem_op, exe_op, dec_op};

    hzc_load_use #(
        .OP_W(OP_W), .REG_W(REG_W), .NSRC(NSRC),
        .OP_LOAD(OP_LOAD), .OP_POP(OP_POP), .NO_REG(NO_REG)
    ) u_lu (
        .exe_op  (exe_op),
        .exe_dst (exe_dst_mem),
        .srcs    (srcs),
        .hit     (lu_hit)
    );

    hzc_ret_track #(
        .OP_W(OP_W), .NSTAGE(NSTAGE), .OP_RET(OP_RET)
    ) u_ret (
        .stage_ops (stage_ops),
        .ret_busy  (ret_busy)
    );

    hzc_mispredict #(
        .OP_W(OP_W), .OP_JXX(OP_JXX)
    ) u_mp (
        .exe_op     (exe_op),
        .cond_true  (exe_cond_true),
        .wrong_path (wrong_path)
    );

    // Priority: a load-to-use hold outranks the return flush on decode;
    // a mispredict flushes regardless of any return behind it.
    always_comb begin
        ctrl_d            = '0;
        ctrl_d.fetch_hold = lu_hit || ret_busy;
        ctrl_d.dec_hold   = lu_hit;
        ctrl_d.exe_flush  = lu_hit || wrong_path;
        if (wrong_path) begin
            ctrl_d.dec_flush = 1'b1;
        end else if (ret_busy && !lu_hit) begin
            ctrl_d.dec_flush = 1'b1;
        end
    end

    assign fetch_stall = ctrl_d.fetch_hold;
    assign dec_stall   = ctrl_d.dec_hold;
    assign dec_bubble  = ctrl_d.dec_flush;
    assign exe_bubble  = ctrl_d.exe_flush;
endmodule

// File: rtl/hzc_checker.sv
module hzc_checker #(
    parameter int OP_W  = 4,
    parameter int REG_W = 4,
    parameter logic [OP_W-1:0]  OP_LOAD = 4'h5,
    parameter logic [OP_W-1:0]  OP_POP  = 4'hB,
    parameter logic [OP_W-1:0]  OP_JXX  = 4'h7,
    parameter logic [OP_W-1:0]  OP_RET  = 4'h9,
    parameter logic [REG_W-1:0] NO_REG  = 4'hF
) (
    input logic [OP_W-1:0]  dec_op,
    input logic [OP_W-1:0]  exe_op,
    input logic [OP_W-1:0]  mem_op,
    input logic [REG_W-1:0] exe_dst_mem,
    input logic [REG_W-1:0] dec_src_a,
    input logic [REG_W-1:0] dec_src_b,
    input logic             exe_cond_true,
    input logic             fetch_stall,
    input logic             dec_stall,
    input logic             dec_bubble,
    input logic             exe_bubble
);
    logic known;
    logic ret_seen;

    assign known = !$isunknown({dec_op, exe_op, mem_op, exe_dst_mem,
                                dec_src_a, dec_src_b, exe_cond_true,
                                fetch_stall, dec_stall, dec_bubble, exe_bubble});
    assign ret_seen = (dec_op == OP_RET) || (exe_op == OP_RET) || (mem_op == OP_RET);

    always_comb begin
        if (known) begin
            assert_dec_exclusive_R9: assert (!(dec_stall && dec_bubble));
            assert_hold_implies_flush_exe_R1: assert (!dec_stall || (exe_bubble && fetch_stall));
            assert_reserved_dst_R2: assert (!(dec_stall && exe_dst_mem == NO_REG));
            assert_ret_holds_fetch_R4: assert (!ret_seen || fetch_stall);
            assert_ret_flushes_dec_R5: assert (!(ret_seen && !dec_stall) || dec_bubble);
            assert_mispredict_flush_R6: assert (!(exe_op == OP_JXX && !exe_cond_true) || (dec_bubble && exe_bubble));
            assert_hold_needs_memread_R3: assert (!dec_stall || exe_op == OP_LOAD || exe_op == OP_POP);
        end
    end
endmodule

bind hazard_ctl hzc_checker #(
    .OP_W(OP_W), .REG_W(REG_W),
    .OP_LOAD(OP_LOAD), .OP_POP(OP_POP), .OP_JXX(OP_JXX),
    .OP_RET(OP_RET), .NO_REG(NO_REG)
) u_chk (
    .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op),
    .exe_dst_mem(exe_dst_mem), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_cond_true(exe_cond_true),
    .fetch_stall(fetch_stall), .dec_stall(dec_stall),
    .dec_bubble(dec_bubble), .exe_bubble(exe_bubble)
);

// File: tb/sim_hazard_ctl.sv
module sim_hazard_ctl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [3:0] dec_op = '0, exe_op = '0, mem_op = '0;
    logic [3:0] exe_dst_mem = '0, dec_src_a = '0, dec_src_b = '0;
    logic       exe_cond_true = 1'b0;
    logic       fetch_stall, dec_stall, dec_bubble, exe_bubble;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hazard_ctl u0 (
        .dec_op(dec_op), .exe_op(exe_op), .mem_op(mem_op),
        .exe_dst_mem(exe_dst_mem), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .exe_cond_true(exe_cond_true),
        .fetch_stall(fetch_stall), .dec_stall(dec_stall),
        .dec_bubble(dec_bubble), .exe_bubble(exe_bubble)
    );

    // Behavioural reference built from the requirement text.
    function automatic bit ref_lu(int eo, int ed, int sa, int sb);
        return (eo == 5 || eo == 11) && ed != 15 && (ed == sa || ed == sb);
    endfunction
    function automatic bit ref_ret(int d, int e, int m);
        int q[$] = '{d, e, m};
        foreach (q[i]) if (q[i] == 9) return 1'b1;
        return 1'b0;
    endfunction

    task automatic check(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b (d=%0d e=%0d m=%0d dst=%0d a=%0d b=%0d c=%0b)",
                     req, what, act, exp, dec_op, exe_op, mem_op,
                     exe_dst_mem, dec_src_a, dec_src_b, exe_cond_true);
        end
    endtask

    task automatic apply(int d, int e, int m, int ed, int sa, int sb, bit c);
        @(posedge clk);
        dec_op = 4'(d); exe_op = 4'(e); mem_op = 4'(m);
        exe_dst_mem = 4'(ed); dec_src_a = 4'(sa); dec_src_b = 4'(sb);
        exe_cond_true = c;
        @(negedge clk);
    endtask

    task automatic compare_all();
        bit lu, rt, mp;
        lu = ref_lu(exe_op, exe_dst_mem, dec_src_a, dec_src_b);
        rt = ref_ret(dec_op, exe_op, mem_op);
        mp = (exe_op == 7) && !exe_cond_true;
        check("R4", "fetch_stall", fetch_stall, lu || rt);
        check("R3", "dec_stall",   dec_stall,   lu);
        check("R5", "dec_bubble",  dec_bubble,  mp || (rt && !lu));
        check("R6", "exe_bubble",  exe_bubble,  mp || lu);
        check("R9", "exclusive",   dec_stall && dec_bubble, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R10: idle inputs give all zeros
        apply(1, 2, 3, 4, 5, 6, 1'b0);
        check("R10", "fetch_stall idle", fetch_stall, 1'b0);
        check("R10", "dec_stall idle",   dec_stall,   1'b0);
        check("R10", "dec_bubble idle",  dec_bubble,  1'b0);
        check("R10", "exe_bubble idle",  exe_bubble,  1'b0);
        // R1: load in execute feeding source b
        apply(0, 5, 0, 3, 1, 3, 1'b1);
        check("R1", "fetch_stall lu", fetch_stall, 1'b1);
        check("R1", "dec_stall lu",   dec_stall,   1'b1);
        check("R1", "exe_bubble lu",  exe_bubble,  1'b1);
        // R1: pop feeding source a
        apply(0, 11, 0, 2, 2, 8, 1'b1);
        check("R1", "dec_stall pop", dec_stall, 1'b1);
        // R2: reserved destination never matches
        apply(0, 5, 0, 15, 15, 15, 1'b1);
        check("R2", "dec_stall noreg", dec_stall, 1'b0);
        check("R2", "exe_bubble noreg", exe_bubble, 1'b0);
        // R6: taken jump is harmless, not-taken flushes
        apply(0, 7, 0, 0, 1, 2, 1'b1);
        check("R6", "dec_bubble taken", dec_bubble, 1'b0);
        apply(0, 7, 0, 0, 1, 2, 1'b0);
        check("R6", "dec_bubble mp", dec_bubble, 1'b1);
        check("R6", "exe_bubble mp", exe_bubble, 1'b1);
        // R7: load/use with return in decode
        apply(9, 5, 0, 4, 4, 0, 1'b1);
        check("R7", "dec_stall prio",  dec_stall,  1'b1);
        check("R7", "dec_bubble prio", dec_bubble, 1'b0);
        // R8: mispredict with return in decode
        apply(9, 7, 0, 0, 0, 0, 1'b0);
        check("R8", "dec_bubble combo",  dec_bubble,  1'b1);
        check("R8", "exe_bubble combo",  exe_bubble,  1'b1);
        check("R8", "fetch_stall combo", fetch_stall, 1'b1);
        // R4/R5: return in memory stage only
        apply(0, 0, 9, 0, 1, 2, 1'b1);
        check("R4", "fetch_stall ret mem", fetch_stall, 1'b1);
        check("R5", "dec_bubble ret mem",  dec_bubble,  1'b1);

        // Sweep every opcode triple, both conditions, four register patterns
        for (int d = 0; d < 16; d++)
            for (int e = 0; e < 16; e++)
                for (int m = 0; m < 16; m++)
                    for (int c = 0; c < 2; c++)
                        for (int p = 0; p < 4; p++) begin
                            case (p)
                                0: apply(d, e, m, 3, 3, 1, c[0]);
                                1: apply(d, e, m, 3, 2, 3, c[0]);
                                2: apply(d, e, m, 15, 15, 15, c[0]);
                                default: apply(d, e, m, 4, 5, 6, c[0]);
                            endcase
                            compare_all();
                        end

        // Sweep every register triple with a load in execute, return in decode (R7, R2)
        for (int ed = 0; ed < 16; ed++)
            for (int sa = 0; sa < 16; sa++)
                for (int sb = 0; sb < 16; sb++) begin
                    apply(9, 5, 0, ed, sa, sb, 1'b1);
                    compare_all();
                end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule